// File: doc/BRIEF.md
# Three-Window Early-Late Symbol Synchronizer

This block takes a stream of signed baseband samples from a frequency discriminator and recovers both the symbol timing and the data bits. It runs a sample counter over a symbol period of `SPS` samples and divides each period into three equal thirds: early, central and late. For each third it keeps a signed running sum and a running sum of sample magnitudes.

At the last sample of every symbol the block does three things. It forms a timing error from the three magnitude sums and uses the sign of that error to lengthen or shorten the next symbol by one sample. It decides the symbol from the sign of the central signed sum. It then differentially decodes that decision against the one before it.

A lock flag goes high once the timing error has stayed small for a run of consecutive symbols. The block sits directly after the demodulator's low-pass filter and feeds a frame decoder with one bit per recovered symbol.

Top module: `els_sync`

## Requirements
- R1: Valid samples are counted by position 0 to SPS-1 within a symbol. Positions below SPS/3 go to the early window, positions below 2*SPS/3 go to the central window, and the rest go to the late window. The end of the sample at position SPS-1 ends the symbol.
- R2: At the end of each symbol the error is e = (M2-M1)-(M2-M3), where M1, M2 and M3 are the early, central and late sums of sample magnitudes.
  - If e>0, the first valid sample after the symbol is discarded (not integrated) and the next symbol then starts at position 0.
  - If e<0, the next symbol starts at position 1, so it is one sample shorter.
  - If e=0, the next symbol starts at position 0.
- R3: The symbol decision is 1 when the signed sum of the central window is zero or positive, and 0 when it is negative.
- R4: bit_o is the XNOR of the current decision and the previous decision. The previous decision is 0 after reset. bit_o holds its value between pulses of bit_valid_o.
- R5: bit_valid_o is a one-cycle pulse on the clock cycle after the edge that accepted a symbol's last sample.
- R6: lock_o rises with the bit_valid_o pulse of the LOCK_SYMS-th consecutive symbol (default 8) whose |e| is below LOCK_THR (default 16). It falls with the pulse of any symbol whose |e| is at or above LOCK_THR. It changes at no other time.
- R7: A cycle with sample_valid_i low has no effect on positions, sums or outputs.
- R8: While rst_ni is low, bit_o, bit_valid_o and lock_o are 0.
- R9: Full-scale negative samples (-2^(SAMPLE_W-1)) over whole symbols are integrated without overflow: magnitude 2^(SAMPLE_W-1), and the central sum stays negative.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sample_i | input | SAMPLE_W | Signed demodulated sample |
| sample_valid_i | input | 1 | Sample strobe |
| bit_o | output | 1 | Differentially decoded bit |
| bit_valid_o | output | 1 | One-cycle strobe for bit_o |
| lock_o | output | 1 | Timing lock indicator |

## Verification
A wrong sample position or a wrong pad state shows at the ports as a bit_valid_o pulse that arrives one or more cycles early or late. This appears by the end of the symbol in which the fault happens. A wrong integral sum or a wrong error sign shifts the timing of every later symbol and corrupts bit_o within a symbol or two. A wrong previous decision flips bit_o at the very next pulse. A wrong lock run count moves the edge of lock_o away from the symbol count the requirements predict. The bench runs a sample-level model alongside the design and compares all three outputs on every cycle, so any such fault is reported in the cycle where it first shows.

// File: rtl/els_sync_pkg.sv
package els_sync_pkg;
  typedef enum logic [1:0] {
    ADJ_NONE  = 2'd0,
    ADJ_SHORT = 2'd1,
    ADJ_LONG  = 2'd2
  } adj_e;

  typedef enum logic [1:0] {
    WIN_EARLY   = 2'd0,
    WIN_CENTRAL = 2'd1,
    WIN_LATE    = 2'd2
  } win_e;
endpackage

// File: rtl/els_sym_ctr.sv
module els_sym_ctr
  import els_sync_pkg::*;
#(
  parameter int SPS = 12
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic valid_i,
  input  adj_e adj_i,
  output win_e win_o,
  output logic skip_o,
  output logic sym_end_o
);
  localparam int THIRD = SPS / 3;
  localparam int CNT_W = $clog2(SPS);

  logic [CNT_W-1:0] cnt_q;
  logic             pad_q;

  assign skip_o    = valid_i & pad_q;
  assign sym_end_o = valid_i & ~pad_q & (cnt_q == CNT_W'(SPS - 1));

  always_comb begin
    if (cnt_q < CNT_W'(THIRD))          win_o = WIN_EARLY;
    else if (cnt_q < CNT_W'(2 * THIRD)) win_o = WIN_CENTRAL;
    else                                win_o = WIN_LATE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      pad_q <= 1'b0;
    end else if (valid_i) begin
      if (pad_q) begin
        pad_q <= 1'b0;
      end else if (sym_end_o) begin
        cnt_q <= (adj_i == ADJ_SHORT) ? CNT_W'(1) : '0;
        pad_q <= (adj_i == ADJ_LONG);
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/els_win_integ.sv
module els_win_integ #(
  parameter int SAMPLE_W = 12,
  parameter int ACC_W    = 17
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       valid_i,
  input  logic                       en_i,
  input  logic                       clr_i,
  input  logic signed [SAMPLE_W-1:0] sample_i,
  output logic signed [ACC_W-1:0]    sum_o,
  output logic        [ACC_W-1:0]    mag_o
);
  logic signed [ACC_W-1:0] sum_q;
  logic        [ACC_W-1:0] mag_q;
  logic [SAMPLE_W-1:0]     mag_s;
  logic signed [ACC_W-1:0] ext_s;

  assign mag_s = sample_i[SAMPLE_W-1] ? (~sample_i + 1'b1) : sample_i;
  assign ext_s = {{(ACC_W-SAMPLE_W){sample_i[SAMPLE_W-1]}}, sample_i};

  // totals include the current sample so the last one of a window counts
  assign sum_o = sum_q + (en_i ? ext_s : '0);
  assign mag_o = mag_q + (en_i ? {{(ACC_W-SAMPLE_W){1'b0}}, mag_s} : '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sum_q <= '0;
      mag_q <= '0;
    end else if (valid_i) begin
      if (clr_i) begin
        sum_q <= '0;
        mag_q <= '0;
      end else if (en_i) begin
        sum_q <= sum_o;
        mag_q <= mag_o;
      end
    end
  end
endmodule

// File: rtl/els_decide.sv
module els_decide #(
  parameter int ACC_W     = 17,
  parameter int ERR_W     = 19,
  parameter int LOCK_SYMS = 8,
  parameter int LOCK_THR  = 16
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    sym_end_i,
  input  logic signed [ACC_W-1:0] central_i,
  input  logic signed [ERR_W-1:0] err_i,
  output logic                    bit_o,
  output logic                    bit_valid_o,
  output logic                    lock_o
);
  localparam int RUN_W = $clog2(LOCK_SYMS + 1);

  logic             prev_q;
  logic             dec;
  logic [ERR_W-1:0] err_abs;
  logic             small_err;
  logic [RUN_W-1:0] run_q, run_d;

  assign dec       = ~central_i[ACC_W-1];
  assign err_abs   = err_i[ERR_W-1] ? (~err_i + 1'b1) : err_i;
  assign small_err = err_abs < ERR_W'(LOCK_THR);

  always_comb begin
    if (!small_err)                        run_d = '0;
    else if (run_q == RUN_W'(LOCK_SYMS))   run_d = run_q;
    else                                   run_d = run_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q      <= 1'b0;
      bit_o       <= 1'b0;
      bit_valid_o <= 1'b0;
      run_q       <= '0;
      lock_o      <= 1'b0;
    end else begin
      bit_valid_o <= sym_end_i;
      if (sym_end_i) begin
        bit_o  <= ~(dec ^ prev_q);
        prev_q <= dec;
        run_q  <= run_d;
        lock_o <= (run_d == RUN_W'(LOCK_SYMS));
      end
    end
  end
endmodule

// File: rtl/els_sync.sv
module els_sync
  import els_sync_pkg::*;
#(
  parameter int SAMPLE_W  = 12,
  parameter int SPS       = 12,
  parameter int LOCK_SYMS = 8,
  parameter int LOCK_THR  = 16
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic signed [SAMPLE_W-1:0] sample_i,
  input  logic                       sample_valid_i,
  output logic                       bit_o,
  output logic                       bit_valid_o,
  output logic                       lock_o
);
  localparam int ACC_W = SAMPLE_W + $clog2(SPS + 1) + 1;
  localparam int ERR_W = ACC_W + 2;

  win_e win;
  logic skip, sym_end;
  adj_e adj;

  logic signed [ACC_W-1:0] sum_tot [3];
  logic        [ACC_W-1:0] mag_tot [3];
  logic signed [ERR_W-1:0] m_early, m_cent, m_late, err;

  els_sym_ctr #(.SPS(SPS)) u_ctr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .valid_i   (sample_valid_i),
    .adj_i     (adj),
    .win_o     (win),
    .skip_o    (skip),
    .sym_end_o (sym_end)
  );

  for (genvar g = 0; g < 3; g++) begin : g_win
    els_win_integ #(.SAMPLE_W(SAMPLE_W), .ACC_W(ACC_W)) u_integ (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .valid_i  (sample_valid_i),
      .en_i     (sample_valid_i & ~skip & (win == win_e'(g))),
      .clr_i    (sym_end),
      .sample_i (sample_i),
      .sum_o    (sum_tot[g]),
      .mag_o    (mag_tot[g])
    );
  end

  assign m_early = ERR_W'(mag_tot[0]);
  assign m_cent  = ERR_W'(mag_tot[1]);
  assign m_late  = ERR_W'(mag_tot[2]);
  assign err     = (m_cent - m_early) - (m_cent - m_late);

  // late energy heavier: boundary too early, stretch next symbol
  always_comb begin
    if (err > 0)      adj = ADJ_LONG;
    else if (err < 0) adj = ADJ_SHORT;
    else              adj = ADJ_NONE;
  end

  els_decide #(
    .ACC_W(ACC_W), .ERR_W(ERR_W), .LOCK_SYMS(LOCK_SYMS), .LOCK_THR(LOCK_THR)
  ) u_decide (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sym_end_i   (sym_end),
    .central_i   (sum_tot[1]),
    .err_i       (err),
    .bit_o       (bit_o),
    .bit_valid_o (bit_valid_o),
    .lock_o      (lock_o)
  );
endmodule

// File: rtl/els_sync_chk.sv
module els_sync_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic sample_valid_i,
  input logic bit_o,
  input logic bit_valid_o,
  input logic lock_o
);
  // R5
  single_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_valid_o |=> !bit_valid_o);
  // R5
  pulse_after_sample_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_valid_o |-> $past(sample_valid_i));
  // R7
  idle_no_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sample_valid_i |=> !bit_valid_o);
  // R4
  bit_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bit_valid_o |-> $stable(bit_o));
  // R6
  lock_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bit_valid_o |-> $stable(lock_o));
endmodule

bind els_sync els_sync_chk u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .sample_valid_i (sample_valid_i),
  .bit_o          (bit_o),
  .bit_valid_o    (bit_valid_o),
  .lock_o         (lock_o)
);

// File: tb/els_sync_tb.sv
module els_sync_tb;
  localparam int SAMPLE_W  = 12;
  localparam int SPS       = 12;
  localparam int THIRD     = SPS / 3;
  localparam int LOCK_SYMS = 8;
  localparam int LOCK_THR  = 16;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic signed [SAMPLE_W-1:0] sample_i = '0;
  logic sample_valid_i = 1'b0;
  logic bit_o, bit_valid_o, lock_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  string tag = "R8";

  // model state
  int m_cnt = 0, m_pad = 0, m_prev = 0, m_ok = 0;
  int m_sum[3], m_mag[3];
  bit exp_valid = 0, exp_bit = 0, exp_lock = 0;

  always #10 clk_i = ~clk_i;

  els_sync #(.SAMPLE_W(SAMPLE_W), .SPS(SPS), .LOCK_SYMS(LOCK_SYMS), .LOCK_THR(LOCK_THR)) u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .sample_i(sample_i), .sample_valid_i(sample_valid_i),
    .bit_o(bit_o), .bit_valid_o(bit_valid_o), .lock_o(lock_o)
  );

  function automatic int iabs(int v);
    return v < 0 ? -v : v;
  endfunction

  task automatic chk(string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // model of R1..R7 per accepted sample
  task automatic model(bit v, int s);
    int w, e;
    exp_valid = 0;
    if (!v) return;
    if (m_pad != 0) begin
      m_pad = 0;
      return;
    end
    w = m_cnt / THIRD;
    m_sum[w] += s;
    m_mag[w] += iabs(s);
    if (m_cnt == SPS - 1) begin
      e = (m_mag[1] - m_mag[0]) - (m_mag[1] - m_mag[2]);
      exp_valid = 1;
      exp_bit = ((m_sum[1] >= 0) == (m_prev != 0));
      m_prev = (m_sum[1] >= 0) ? 1 : 0;
      if (iabs(e) < LOCK_THR) m_ok = (m_ok < LOCK_SYMS) ? m_ok + 1 : m_ok;
      else m_ok = 0;
      exp_lock = (m_ok == LOCK_SYMS);
      m_cnt = (e < 0) ? 1 : 0;
      m_pad = (e > 0) ? 1 : 0;
      for (int k = 0; k < 3; k++) begin m_sum[k] = 0; m_mag[k] = 0; end
    end else begin
      m_cnt++;
    end
  endtask

  task automatic step(bit v, int s);
    @(negedge clk_i);
    chk("bit_valid_o", bit_valid_o, exp_valid);
    if (exp_valid) chk("bit_o", bit_o, exp_bit);
    chk("lock_o", lock_o, exp_lock);
    sample_valid_i = v;
    sample_i = SAMPLE_W'(s);
    model(v, s);
  endtask

  task automatic sym(int a, int b, int c);
    for (int i = 0; i < SPS; i++) step(1'b1, (i < THIRD) ? a : (i < 2 * THIRD) ? b : c);
  endtask

  initial begin
    void'($urandom(32'd24681));
    for (int k = 0; k < 3; k++) begin m_sum[k] = 0; m_mag[k] = 0; end
    repeat (3) @(negedge clk_i);
    // R8 reset state
    chk("reset bit_o", bit_o, 0);
    chk("reset bit_valid_o", bit_valid_o, 0);
    chk("reset lock_o", lock_o, 0);
    rst_ni = 1'b1;

    // R1 R3 R4 R6: all-zero symbols, zero error, decision 1 each
    tag = "R1 R3 R4 R6";
    for (int n = 0; n < 10; n++) sym(0, 0, 0);
    step(1'b0, 0);
    chk("lock after zero run", lock_o, 1);

    // R9 full-scale negative
    tag = "R9 R3";
    for (int n = 0; n < 3; n++) sym(-2048, -2048, -2048);

    // R2 late-heavy then early-heavy symbols, also drop lock (R6)
    tag = "R2 R6";
    sym(0, 100, 1000);
    sym(0, 100, 0);
    sym(1000, -100, 0);
    sym(0, -100, 0);
    sym(500, 0, 500);

    // R7 gaps of invalid samples carrying garbage
    tag = "R7";
    for (int i = 0; i < 3 * SPS; i++) begin
      step(1'b0, 2047);
      step(1'b1, (i % 5) * 37 - 60);
    end

    // random symbol streams with valid gaps and noise
    tag = "R1 R2 R3 R4 R5 R6 R7";
    for (int n = 0; n < 400; n++) begin
      int amp, ph;
      amp = ($urandom % 2) ? 600 : -600;
      ph  = $urandom % 3;
      for (int i = 0; i < SPS + ph - 1; i++) begin
        if ($urandom % 4 == 0) step(1'b0, int'($urandom % 4096) - 2048);
        step(1'b1, amp + int'($urandom % 41) - 20);
      end
    end
    // settle on quiet symbols to reach lock again
    tag = "R6";
    for (int n = 0; n < 12; n++) sym(300, 300, 300);
    step(1'b0, 0);
    step(1'b0, 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule